// File: doc/BRIEF.md
# Erase-Block Write Guard

This block holds the write-protection state of every erase block of a flash array and rules on each program or erase request before the array controller starts work. Each block carries two state bits. The lock bit blocks writes. The lock-down bit pins the lock bit in place while the write-protect pin is held low. The command decoder delivers lock, unlock and lock-down commands here together with a block index. The array sequencer raises a start request with a target block and later reports completion. Software can read back the two bits of any block through an indexed status port.

Decisions on requests come from a two-state controller. In `IDLE`, a start request is judged against the target's lock bit and the supply-lockout flag, which is sampled only at that moment. The transition `IDLE -> RUN` is taken when the request is granted. `IDLE -> IDLE` is taken when it is denied, and the sticky protection error is set. In `RUN`, further start requests are ignored and changes of the lockout flag have no effect. The transition `RUN -> IDLE` is taken when the sequencer reports completion.

Top module: `blk_guard`

## Requirements
- R1: While reset is asserted and afterwards until a command arrives, every block reads lock=1 and lock-down=0. The outputs grant_valid, prot_err and op_active are low.
- R2: A lock command (cmd_op=01) sets and an unlock command (cmd_op=10) clears the lock bit of the indexed block only, at the clock edge that samples the command. A status query issued in the following cycle sees the new value.
- R3: A lock-down command (cmd_op=11) sets both the lock and the lock-down bit of the indexed block. The lock-down bit is cleared only by reset.
- R4: With wp_pin low, lock and unlock commands to a block whose lock-down bit is set leave its state unchanged and do not set prot_err.
- R5: With wp_pin high, a locked-down block can be unlocked and locked again, and its lock-down bit stays set.
- R6: In IDLE, op_start produces a one-cycle grant_valid on the next cycle. grant_ok is 1 exactly when the target block is unlocked and vpp_lockout is low.
- R7: When vpp_lockout is high at op_start, the request is denied whatever the block state.
- R8: A denied request sets prot_err. prot_err stays set until clr_err is pulsed, and a denial in the same cycle as clr_err leaves it set.
- R9: A granted request raises op_active on the next cycle until the cycle after op_done. During that time a change of vpp_lockout does not end the operation, and op_start produces no grant_valid and no error.
- R10: The status port returns the lock bit on qry_lock and the lock-down bit on qry_down for the block at qry_idx. Both values are registered and appear one cycle after qry_idx is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | Protection command: 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmd_idx | input | 7 | Block index of the command |
| wp_pin | input | 1 | Write-protect pin; low enforces lock-down |
| vpp_lockout | input | 1 | Supply too low for program or erase |
| op_start | input | 1 | Program or erase start request |
| op_idx | input | 7 | Target block of the request |
| op_done | input | 1 | Running operation has completed |
| clr_err | input | 1 | Clears the protection error flag |
| qry_idx | input | 7 | Block index for status readout |
| grant_valid | output | 1 | A decision is presented this cycle |
| grant_ok | output | 1 | Decision: 1 allow, 0 deny |
| prot_err | output | 1 | Sticky protection error |
| op_active | output | 1 | A granted operation is running |
| qry_lock | output | 1 | Lock bit of the queried block |
| qry_down | output | 1 | Lock-down bit of the queried block |

## Verification
The bench targets the interaction between the write-protect pin and the lock-down bit. If a design applied the pin to every block, an ordinary block would refuse unlock while the pin is low. If a design ignored the pin, a locked-down block would unlock. The bench also checks that unlock leaves the lock-down bit set and that only reset clears it. A design that cleared the bit too early would let a later unlock succeed with the pin low. It raises the lockout flag in the middle of a running operation and issues a second start request then. A design that re-sampled the flag would drop op_active, and a design that accepted the request would raise grant_valid or prot_err.

// File: rtl/blk_guard_pkg.sv
package blk_guard_pkg;
    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_LOCK   = 2'b01,
        CMD_UNLOCK = 2'b10,
        CMD_DOWN   = 2'b11
    } prot_cmd_e;

    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_RUN  = 1'b1
    } gate_st_e;
endpackage

// File: rtl/blk_lock_array.sv
module blk_lock_array
    import blk_guard_pkg::*;
#(
    parameter int NUM_BLOCKS = 128,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  prot_cmd_e        cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic             wp_pin,
    input  logic [IDX_W-1:0] chk_idx,
    input  logic [IDX_W-1:0] qry_idx,
    output logic             chk_locked,
    output logic             qry_lock,
    output logic             qry_down
);
    logic [NUM_BLOCKS-1:0] lock_q;
    logic [NUM_BLOCKS-1:0] down_q;

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        logic lk, dn;
        logic hit, frozen;
        assign hit    = (32'(cmd_idx) == i);
        assign frozen = dn & ~wp_pin;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lk <= 1'b1;
                dn <= 1'b0;
            end else if (hit) begin
                unique case (cmd_op)
                    CMD_LOCK:   if (!frozen) lk <= 1'b1;
                    CMD_UNLOCK: if (!frozen) lk <= 1'b0;
                    CMD_DOWN: begin
                        lk <= 1'b1;
                        dn <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        assign lock_q[i] = lk;
        assign down_q[i] = dn;
    end

    assign chk_locked = (32'(chk_idx) < NUM_BLOCKS) ? lock_q[chk_idx] : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qry_lock <= 1'b1;
            qry_down <= 1'b0;
        end else if (32'(qry_idx) < NUM_BLOCKS) begin
            qry_lock <= lock_q[qry_idx];
            qry_down <= down_q[qry_idx];
        end else begin
            qry_lock <= 1'b1;
            qry_down <= 1'b0;
        end
    end

    // R3: lock-down bits never fall outside reset
    assert_down_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(down_q) & ~down_q) == '0));

    // R3: lock-down command sets both bits of its block
    assert_down_sets_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == CMD_DOWN) |=> (lock_q[$past(cmd_idx)] && down_q[$past(cmd_idx)]));

    // R4: protected block keeps its lock bit
    assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_op == CMD_LOCK || cmd_op == CMD_UNLOCK) && down_q[cmd_idx] && !wp_pin)
        |=> (lock_q[$past(cmd_idx)] == $past(lock_q[cmd_idx])));
endmodule

// File: rtl/blk_op_gate.sv
module blk_op_gate
    import blk_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic vpp_lockout,
    input  logic blk_locked,
    input  logic op_done,
    input  logic clr_err,
    output logic grant_valid,
    output logic grant_ok,
    output logic prot_err,
    output logic op_active
);
    gate_st_e st_q, st_d;
    logic req, allow;

    assign req   = (st_q == GATE_IDLE) && op_start;
    assign allow = !vpp_lockout && !blk_locked;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GATE_IDLE: if (req && allow) st_d = GATE_RUN;
            GATE_RUN:  if (op_done)      st_d = GATE_IDLE;
            default:                     st_d = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GATE_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_ok    <= 1'b0;
            prot_err    <= 1'b0;
        end else begin
            grant_valid <= req;
            grant_ok    <= req && allow;
            if (req && !allow) prot_err <= 1'b1;
            else if (clr_err)  prot_err <= 1'b0;
        end
    end

    assign op_active = (st_q == GATE_RUN);

    // R6: a start in IDLE always yields a decision
    assert_start_decides_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GATE_IDLE && op_start) |=> grant_valid);

    // R7: lockout at start forces denial
    assert_lockout_denies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GATE_IDLE && op_start && vpp_lockout) |=> (!grant_ok && prot_err));

    // R8: locked target is denied and flagged
    assert_locked_denies_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GATE_IDLE && op_start && blk_locked) |=> (!grant_ok && prot_err));

    // R8: error flag is sticky until cleared
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_err && !clr_err) |=> prot_err);

    // R9: running operation ends only on op_done
    assert_run_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GATE_RUN && !op_done) |=> (st_q == GATE_RUN));

    // R9: no decision while running
    assert_no_grant_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GATE_RUN) |=> !grant_valid);
endmodule

// File: rtl/blk_guard.sv
module blk_guard
    import blk_guard_pkg::*;
#(
    parameter int NUM_BLOCKS = 128,
    parameter int IDX_W      = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic             wp_pin,
    input  logic             vpp_lockout,
    input  logic             op_start,
    input  logic [IDX_W-1:0] op_idx,
    input  logic             op_done,
    input  logic             clr_err,
    input  logic [IDX_W-1:0] qry_idx,
    output logic             grant_valid,
    output logic             grant_ok,
    output logic             prot_err,
    output logic             op_active,
    output logic             qry_lock,
    output logic             qry_down
);
    logic tgt_locked;

    blk_lock_array #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_op     (prot_cmd_e'(cmd_op)),
        .cmd_idx    (cmd_idx),
        .wp_pin     (wp_pin),
        .chk_idx    (op_idx),
        .qry_idx    (qry_idx),
        .chk_locked (tgt_locked),
        .qry_lock   (qry_lock),
        .qry_down   (qry_down)
    );

    blk_op_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_start    (op_start),
        .vpp_lockout (vpp_lockout),
        .blk_locked  (tgt_locked),
        .op_done     (op_done),
        .clr_err     (clr_err),
        .grant_valid (grant_valid),
        .grant_ok    (grant_ok),
        .prot_err    (prot_err),
        .op_active   (op_active)
    );
endmodule

// File: tb/tb_blk_guard.sv
module tb_blk_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 128;
    localparam int IW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [IW-1:0] cmd_idx = '0, op_idx = '0, qry_idx = '0;
    logic wp_pin = 1'b1, vpp_lockout = 1'b0, op_start = 1'b0, op_done = 1'b0, clr_err = 1'b0;
    logic grant_valid, grant_ok, prot_err, op_active, qry_lock, qry_down;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_guard #(.NUM_BLOCKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .wp_pin(wp_pin), .vpp_lockout(vpp_lockout), .op_start(op_start),
        .op_idx(op_idx), .op_done(op_done), .clr_err(clr_err), .qry_idx(qry_idx),
        .grant_valid(grant_valid), .grant_ok(grant_ok), .prot_err(prot_err),
        .op_active(op_active), .qry_lock(qry_lock), .qry_down(qry_down)
    );

    // {cmd[1:0], idx[6:0], wp, exp_lock, exp_down}
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {2'b10, 7'd5,   1'b1, 1'b0, 1'b0},  // R2 unlock
        {2'b01, 7'd5,   1'b1, 1'b1, 1'b0},  // R2 lock
        {2'b10, 7'd5,   1'b1, 1'b0, 1'b0},  // R2 unlock again
        {2'b10, 7'd127, 1'b1, 1'b0, 1'b0},  // R2 top index
        {2'b11, 7'd9,   1'b1, 1'b1, 1'b1},  // R3 lock-down
        {2'b10, 7'd9,   1'b0, 1'b1, 1'b1},  // R4 unlock refused
        {2'b10, 7'd9,   1'b1, 1'b0, 1'b1},  // R5 unlock allowed
        {2'b01, 7'd9,   1'b0, 1'b0, 1'b1},  // R4 lock refused
        {2'b01, 7'd9,   1'b1, 1'b1, 1'b1},  // R5 relock
        {2'b11, 7'd0,   1'b0, 1'b1, 1'b1},  // R3 lock-down with pin low
        {2'b10, 7'd0,   1'b0, 1'b1, 1'b1},  // R4 refused
        {2'b10, 7'd4,   1'b0, 1'b0, 1'b0}   // R4 pin spares normal block
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic query(input logic [IW-1:0] idx, input logic el, input logic ed, input string tag);
        qry_idx = idx;
        @(negedge clk);
        chk({tag, " lock"}, 32'(qry_lock), 32'(el));
        chk({tag, " down"}, 32'(qry_down), 32'(ed));
    endtask

    task automatic request(input logic [IW-1:0] idx, input logic lo);
        op_idx = idx; vpp_lockout = lo; op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 grant_valid", 32'(grant_valid), 0);
        chk("R1 prot_err", 32'(prot_err), 0);
        chk("R1 op_active", 32'(op_active), 0);
        rst_n = 1'b1;
        @(negedge clk);
        query(7'd0, 1'b1, 1'b0, "R1 blk0");
        query(7'd127, 1'b1, 1'b0, "R1 blk127");

        // R2 R3 R4 R5 R10: command table
        for (int v = 0; v < NV; v++) begin
            cmd_op = VEC[v][11:10]; cmd_idx = VEC[v][9:3]; wp_pin = VEC[v][2];
            @(negedge clk);
            cmd_op = 2'b00;
            query(VEC[v][9:3], VEC[v][1], VEC[v][0], $sformatf("R2/R3/R4/R5/R10 vec%0d", v));
        end
        chk("R4 no error from refused cmd", 32'(prot_err), 0);
        query(7'd6, 1'b1, 1'b0, "R2 neighbour untouched");
        wp_pin = 1'b1;

        // R6: grant on unlocked block
        request(7'd5, 1'b0);
        chk("R6 grant_valid", 32'(grant_valid), 1);
        chk("R6 grant_ok", 32'(grant_ok), 1);
        chk("R9 op_active", 32'(op_active), 1);
        // R9: lockout rises mid-run, second start ignored
        vpp_lockout = 1'b1;
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        chk("R9 no grant in run", 32'(grant_valid), 0);
        chk("R9 no error in run", 32'(prot_err), 0);
        chk("R9 still active", 32'(op_active), 1);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        chk("R9 done ends run", 32'(op_active), 0);

        // R7: lockout denies unlocked block
        request(7'd5, 1'b1);
        chk("R7 grant_valid", 32'(grant_valid), 1);
        chk("R7 grant_ok", 32'(grant_ok), 0);
        chk("R8 err set", 32'(prot_err), 1);
        @(negedge clk);
        chk("R8 err sticky", 32'(prot_err), 1);
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        chk("R8 err cleared", 32'(prot_err), 0);

        // R6: locked block denied
        request(7'd6, 1'b0);
        chk("R6 locked deny", 32'(grant_ok), 0);
        chk("R8 locked err", 32'(prot_err), 1);
        chk("R6 no run", 32'(op_active), 0);
        // R8: denial wins over clear
        clr_err = 1'b1;
        request(7'd6, 1'b0);
        clr_err = 1'b0;
        chk("R8 set wins", 32'(prot_err), 1);

        // R3: reset clears lock-down
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        query(7'd9, 1'b1, 1'b0, "R3 reset clears down");
        cmd_op = 2'b10; cmd_idx = 7'd9; wp_pin = 1'b0;
        @(negedge clk);
        cmd_op = 2'b00;
        query(7'd9, 1'b0, 1'b0, "R3 unlock after reset");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule